// File: doc/BRIEF.md
# Eight-Input Converter Sequencer

This controller runs the conversion handshake of an eight-input analog-to-digital front end. It works in one of two modes, chosen by a run input.

When run is high, it steps through eight programmable slots. Each slot is a channel mask, and every channel set in that mask is converted in turn. When run is low, it waits for a software start strobe. The strobe converts the single channel named on a 3-bit select input and then raises an end-of-conversion flag.

Every conversion has two parts. First comes a sample phase, whose length comes from that channel's own sample-time field. Then comes a fixed 12-tick conversion phase. Both parts are timed in ticks of a divided clock. The analog side is reduced to a start pulse and a done pulse. Status outputs report the following:
- busy
- the sample phase
- whether sequencing is active
- the slot and channel being converted

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all of these are 0: busy, sampling, eoc, running, cur_slot, cur_chan, conv_start and conv_done.
- R2: In software mode the block starts a conversion on sw_start only when run is low, pwr_on is high and the block is idle.
  - The conversion uses channel sw_chan (0 to 7).
  - conv_start pulses in the first cycle of the conversion, and cur_chan takes the value of sw_chan.
  - A sw_start that arrives while busy, or while run is high, is ignored.
- R3: eoc drops to 0 when a software conversion starts and goes to 1 in the cycle after it completes. A sequenced conversion does not change eoc.
- R4: The sample phase lasts (S+1)*(N+1) clock cycles. S is the channel's sample time, and N is the value on clk_div. N = 0 divides by 1, and N = k divides by k+1.
- R5: The conversion phase lasts 12*(N+1) cycles. conv_done pulses for one cycle in the cycle after busy would otherwise end.
- R6: The mask of slot k is slot_masks[8k+6:8k]. Bit c of that mask enables channel c, for c from 0 to 6. Bit 8k+7 is ignored. Conversion order is ascending slot, and ascending channel within a slot.
- R7: Slots with an empty mask are skipped, and after slot 7 the order wraps to slot 0. If run is high and every mask is zero, no conversion starts.
- R8: While run stays high, the next sequenced conversion starts in the cycle right after the previous one ends. busy does not drop between them.
- R9: If run is cleared during a sequenced conversion, that conversion completes with a conv_done pulse. The block then goes idle with running low.
- R10: While pwr_on is low, the block is idle in the next cycle: busy and running are 0, any running conversion is abandoned without conv_done, and no start is accepted.
- R11: sampling is high only during the sample phase, and never while busy is low.
- R12: The sample time of channel c is samp_times[8c+6:8c]. Bit 8c+7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | 1 = converter active, 0 = powered down |
| run | input | 1 | 1 = sequencing, 0 = software mode |
| sw_start | input | 1 | Software start strobe |
| sw_chan | input | 3 | Channel for software mode |
| clk_div | input | 5 | Divider value N, giving a tick every N+1 cycles |
| slot_masks | input | 64 | Eight slot masks, one byte per slot |
| samp_times | input | 64 | Eight sample times, one byte per channel |
| conv_start | output | 1 | Start pulse to the analog side |
| conv_done | output | 1 | Done pulse from the conversion timing |
| busy | output | 1 | Conversion in progress |
| sampling | output | 1 | Sample phase active |
| eoc | output | 1 | Software conversion finished |
| running | output | 1 | Sequenced conversion in progress |
| cur_slot | output | 3 | Slot of the current or last sequenced conversion |
| cur_chan | output | 3 | Channel of the current or last conversion |

## Verification
The assertions assume that clk_div and the sample time of the active channel stay constant while a conversion runs. This is needed because the phase lengths are fixed when a conversion starts. The stimulus changes the divider, the masks and the sample times only while busy is low, and changes run and pwr_on at any time. The bench's reference model counts cycles per phase, not ticks. Each slot and channel decision is checked against the masks as they stand at the edge where the decision is made.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int SLOTS = 8,
  parameter int CHANS = 8,
  parameter int MASK_W = 7,
  parameter int ST_W = 7,
  parameter int DIV_W = 5,
  parameter int CONV_TICKS = 12,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CH_W = $clog2(CHANS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_on,
  input  logic                  run,
  input  logic                  sw_start,
  input  logic [CH_W-1:0]       sw_chan,
  input  logic [DIV_W-1:0]      clk_div,
  input  logic [SLOTS*8-1:0]    slot_masks,
  input  logic [CHANS*8-1:0]    samp_times,
  output logic                  conv_start,
  output logic                  conv_done,
  output logic                  busy,
  output logic                  sampling,
  output logic                  eoc,
  output logic                  running,
  output logic [SLOT_W-1:0]     cur_slot,
  output logic [CH_W-1:0]       cur_chan
);
  localparam int POS = SLOTS * MASK_W;
  localparam int CT_W = $clog2(CONV_TICKS);
  localparam int PH_W = (ST_W > CT_W) ? ST_W : CT_W;

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_CONV} st_t;
  st_t st;

  logic [DIV_W-1:0]  divcnt;
  logic [PH_W-1:0]   ph;
  logic              seq_mode, eoc_q, start_q, done_q;
  logic [SLOT_W-1:0] slot_q, nx_slot;
  logic [CH_W-1:0]   chan_q, nx_chan, go_chan;
  logic              found;

  wire tick   = (divcnt == clk_div);
  wire finish = (st == S_CONV) && tick && (ph == '0);

  always_comb begin
    int base;
    int idx;
    base = seq_mode ? (int'(slot_q) * MASK_W + int'(chan_q)) : POS - 1;
    found = 1'b0;
    nx_slot = '0;
    nx_chan = '0;
    for (int k = 1; k <= POS; k++) begin
      idx = (base + k) % POS;
      if (!found && slot_masks[(idx / MASK_W) * 8 + (idx % MASK_W)]) begin
        found = 1'b1;
        nx_slot = SLOT_W'(idx / MASK_W);
        nx_chan = CH_W'(idx % MASK_W);
      end
    end
  end

  wire seq_go = pwr_on && run && found && ((st == S_IDLE) || (finish && seq_mode));
  wire sw_go  = pwr_on && !run && sw_start && (st == S_IDLE);
  assign go_chan = seq_go ? nx_chan : sw_chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      divcnt <= '0;
      ph <= '0;
      seq_mode <= 1'b0;
      eoc_q <= 1'b0;
      start_q <= 1'b0;
      done_q <= 1'b0;
      slot_q <= '0;
      chan_q <= '0;
    end else begin
      start_q <= 1'b0;
      done_q <= 1'b0;
      if (!pwr_on) begin
        st <= S_IDLE;
        seq_mode <= 1'b0;
      end else if (seq_go || sw_go) begin
        st <= S_SAMP;
        ph <= PH_W'(samp_times[int'(go_chan) * 8 +: ST_W]);
        divcnt <= '0;
        start_q <= 1'b1;
        chan_q <= go_chan;
        seq_mode <= seq_go;
        if (seq_go) slot_q <= nx_slot;
        if (sw_go) eoc_q <= 1'b0;
        if (finish) done_q <= 1'b1;
      end else if (finish) begin
        st <= S_IDLE;
        seq_mode <= 1'b0;
        done_q <= 1'b1;
        if (!seq_mode) eoc_q <= 1'b1;
      end else if (st != S_IDLE) begin
        divcnt <= tick ? '0 : divcnt + 1'b1;
        if (tick) begin
          if (ph == '0) begin
            st <= S_CONV;
            ph <= PH_W'(CONV_TICKS - 1);
          end else begin
            ph <= ph - 1'b1;
          end
        end
      end
    end
  end

  assign conv_start = start_q;
  assign conv_done  = done_q;
  assign busy       = (st != S_IDLE);
  assign sampling   = (st == S_SAMP);
  assign eoc        = eoc_q;
  assign running    = seq_mode;
  assign cur_slot   = slot_q;
  assign cur_chan   = chan_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CH_W = 3,
  parameter int MASK_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pwr_on,
  input logic            conv_start,
  input logic            conv_done,
  input logic            busy,
  input logic            sampling,
  input logic            eoc,
  input logic            running,
  input logic [CH_W-1:0] cur_chan
);
  a_r11_samp_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sampling |-> busy);
  a_r2_start_samples: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> sampling);
  a_r3_eoc_low_sw_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !running) |-> !eoc);
  a_r5_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (!busy || conv_start));
  a_r10_pwr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (!busy && !running));
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> !busy);
  a_r8_running_busy: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> busy);
  a_r6_seq_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (int'(cur_chan) < MASK_W));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W), .MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .conv_start(conv_start),
  .conv_done(conv_done), .busy(busy), .sampling(sampling), .eoc(eoc),
  .running(running), .cur_chan(cur_chan)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, pwr_on = 1'b0, run = 1'b0, sw_start = 1'b0;
  logic [2:0] sw_chan = '0;
  logic [4:0] clk_div = '0;
  logic [63:0] slot_masks = '0, samp_times = '0;
  logic conv_start, conv_done, busy, sampling, eoc, running;
  logic [2:0] cur_slot, cur_chan;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .run(run), .sw_start(sw_start),
    .sw_chan(sw_chan), .clk_div(clk_div), .slot_masks(slot_masks),
    .samp_times(samp_times), .conv_start(conv_start), .conv_done(conv_done),
    .busy(busy), .sampling(sampling), .eoc(eoc), .running(running),
    .cur_slot(cur_slot), .cur_chan(cur_chan)
  );

  int tests = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model: counts cycles left in each phase
  int m_st = 0, m_rem = 0, m_slot = 0, m_chan = 0;
  bit m_seq = 0, m_eoc = 0, m_start = 0, m_done = 0;
  int f_slot, f_chan;

  function automatic bit find_next(input int from);
    for (int k = 1; k <= 56; k++) begin
      int p = (from + k) % 56;
      if (slot_masks[(p / 7) * 8 + (p % 7)]) begin
        f_slot = p / 7;
        f_chan = p % 7;
        return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic launch(input int ch);
    m_st = 1;
    m_chan = ch;
    m_rem = (int'(samp_times[ch*8 +: 7]) + 1) * (int'(clk_div) + 1);
    m_start = 1;
  endtask

  always @(posedge clk) begin
    m_start = 0;
    m_done = 0;
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_slot = 0; m_chan = 0; m_seq = 0; m_eoc = 0;
    end else if (!pwr_on) begin
      m_st = 0; m_seq = 0;
    end else if (m_st == 0) begin
      if (run) begin
        if (find_next(55)) begin m_seq = 1; m_slot = f_slot; launch(f_chan); end
      end else if (sw_start) begin
        m_seq = 0; m_eoc = 0; launch(int'(sw_chan));
      end
    end else begin
      m_rem--;
      if (m_rem == 0) begin
        if (m_st == 1) begin
          m_st = 2;
          m_rem = 12 * (int'(clk_div) + 1);
        end else begin
          m_done = 1;
          if (m_seq && run && find_next(m_slot * 7 + m_chan)) begin
            m_slot = f_slot; launch(f_chan);
          end else begin
            if (!m_seq) m_eoc = 1;
            m_st = 0; m_seq = 0;
          end
        end
      end
    end
  end

  int rec_slot[$], rec_chan[$];

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (m_st != 0), "R8 busy", busy, m_st != 0);
      chk(sampling == (m_st == 1), "R11 sampling", sampling, m_st == 1);
      chk(eoc == m_eoc, "R3 eoc", eoc, m_eoc);
      chk(running == m_seq, "R9 running", running, m_seq);
      chk(int'(cur_slot) == m_slot, "R6 cur_slot", cur_slot, m_slot);
      chk(int'(cur_chan) == m_chan, "R6 cur_chan", cur_chan, m_chan);
      chk(conv_start == m_start, "R2 conv_start", conv_start, m_start);
      chk(conv_done == m_done, "R5 conv_done", conv_done, m_done);
      if (conv_start && running) begin
        rec_slot.push_back(int'(cur_slot));
        rec_chan.push_back(int'(cur_chan));
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  int exp_s[6] = '{0, 0, 2, 7, 0, 0};
  int exp_c[6] = '{0, 2, 6, 1, 0, 2};

  initial begin
    int ns, nb;
    bit seen;
    repeat (3) @(negedge clk);
    chk({busy, sampling, eoc, running, conv_start, conv_done} == 6'b0 &&
        cur_slot == 0 && cur_chan == 0, "R1 reset outputs", busy, 0);
    rst_n = 1'b1;
    samp_times = 64'h08_07_06_05_84_03_02_01;
    slot_masks = 64'h02_00_00_00_00_40_80_05;
    pwr_on = 1'b1;
    @(negedge clk);

    // software conversion, channel 3, divide by 3
    clk_div = 5'd2; sw_chan = 3'd3; sw_start = 1'b1;
    ns = 0; nb = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      sw_start = 1'b0;
      if (i == 5) begin sw_start = 1'b1; sw_chan = 3'd5; end
      if (sampling) ns++;
      if (busy) nb++;
      if (conv_done) break;
    end
    sw_start = 1'b0;
    chk(ns == 15, "R4 R12 sample cycles ch3", ns, 15);
    chk(nb - ns == 36, "R5 conversion cycles", nb - ns, 36);
    chk(eoc == 1'b1, "R3 eoc after finish", eoc, 1);
    chk(cur_chan == 3'd3, "R2 channel kept", cur_chan, 3);
    @(negedge clk);
    chk(busy == 1'b0, "R2 start during busy ignored", busy, 0);

    // software conversion, channel 7, no division
    clk_div = 5'd0; sw_chan = 3'd7; sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    chk(cur_chan == 3'd7 && busy, "R2 channel 7 start", cur_chan, 7);
    chk(eoc == 1'b0, "R3 eoc low while busy", eoc, 0);
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);

    // sequencing
    rec_slot.delete(); rec_chan.delete();
    run = 1'b1;
    for (int i = 0; i < 2000 && rec_slot.size() < 6; i++) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      chk(i < rec_slot.size() && rec_slot[i] == exp_s[i], "R7 slot order",
          i < rec_slot.size() ? rec_slot[i] : -1, exp_s[i]);
      chk(i < rec_chan.size() && rec_chan[i] == exp_c[i], "R6 channel order",
          i < rec_chan.size() ? rec_chan[i] : -1, exp_c[i]);
    end
    run = 1'b0;
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) begin seen = conv_done; break; end
    end
    chk(seen && !running, "R9 stop finishes current", seen, 1);

    // empty masks with ignored top bits
    slot_masks = 64'h80_80_80_80_80_80_80_80;
    run = 1'b1; nb = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy) nb++;
    end
    chk(nb == 0, "R7 no conversion on empty masks", nb, 0);
    run = 1'b0;

    // power down mid conversion
    slot_masks = 64'h02_00_00_00_00_40_80_05;
    run = 1'b1;
    repeat (4) @(negedge clk);
    pwr_on = 1'b0;
    @(negedge clk);
    chk(!busy && !running, "R10 power down idles", busy, 0);
    run = 1'b0; sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    @(negedge clk);
    chk(!busy, "R10 start blocked when off", busy, 0);
    pwr_on = 1'b1;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule